// File: doc/BRIEF.md
# DC-only residual fill

This block is the shortcut path of an inverse transform unit for a coefficient block whose only nonzero entry is the DC term. In that case the full two-pass transform reduces to a single rounding step. The block takes the signed DC coefficient, the block size and the sample bit depth. It sign-extends the coefficient, adds a depth-dependent offset that carries an extra +1, and shifts the sum right arithmetically once. It then sends that one residual to every position of the N×N block.

A request is accepted with a valid/ready handshake, and only while the block is idle. The result then leaves as a stream of residual words, one word per cycle while the consumer is ready. The final word of the block is flagged with `blk_last`. After that word is taken, the block goes back to idle. Deciding that a block is DC-only, and adding the residuals to a prediction, are left to neighbouring logic.

Top module: `dc_fill`

## Requirements
- R1: Each output word equals (sext(dc) + (1 << (14 - bd)) + 1) >>> (15 - bd), where dc is the 16-bit two's-complement coefficient sign-extended before the add and bd is the bit depth selected by `cfg_depth`: 0 selects 8, 1 selects 10, 2 selects 12.
- R2: The `cfg_depth` code 3 behaves exactly like code 2 (12-bit).
- R3: The output word is the low 16 bits of the shifted result, read as signed two's complement.
- R4: The `cfg_size` code selects N: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32. Each accepted request produces exactly N*N transferred words, all with the same value.
- R5: `blk_last` is high on transferred word N*N-1 and on no other word.
- R6: A word transfers on every rising edge at which `blk_valid` and `blk_ready` are both high. While `blk_ready` is low, `blk_valid`, `blk_data` and `blk_last` hold their values.
- R7: `dc_ready` is high exactly when no block is being streamed. A `dc_valid` pulse while streaming is ignored and does not change the words still to come.
- R8: After reset, `blk_valid` is low and `dc_ready` is high.
- R9: In the cycle after the last word transfers, `blk_valid` is low and `dc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dc_valid | input | 1 | DC request present |
| dc_ready | output | 1 | Block idle, request can be taken |
| dc_coef | input | 16 | Signed DC coefficient |
| cfg_size | input | 2 | Block size code (4/8/16/32) |
| cfg_depth | input | 2 | Bit depth code (8/10/12, 3 acts as 12) |
| blk_valid | output | 1 | Residual word present |
| blk_ready | input | 1 | Consumer takes the word |
| blk_data | output | 16 | Signed residual word |
| blk_last | output | 1 | Final word of the block |

## Verification
The assertions check the handshake on every cycle. They check that the request side is ready exactly when the stream is idle, that the stream holds steady under back-pressure, and that the value stays the same through a block. They also check that the last flag falls on the N*N-th transfer for the size latched at acceptance, and that the stream drops after the last transfer. The numeric result cannot be checked this way, because it depends on the rounding formula for each depth and on the extreme coefficients. The directed scenarios cover every size and depth with the largest positive, largest negative and zero coefficients, stalls from the consumer, and requests ignored while busy.

// File: rtl/dc_fill.sv
module dc_fill #(
  parameter int COEF_W  = 16,
  parameter int RES_W   = 16,
  parameter int LOG2_NMAX = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dc_valid,
  output logic               dc_ready,
  input  logic [COEF_W-1:0]  dc_coef,
  input  logic [1:0]         cfg_size,
  input  logic [1:0]         cfg_depth,
  output logic               blk_valid,
  input  logic               blk_ready,
  output logic [RES_W-1:0]   blk_data,
  output logic               blk_last
);
  localparam int ACC_W = COEF_W + 2;
  localparam int CNT_W = 2 * LOG2_NMAX;

  logic                    busy;
  logic [CNT_W-1:0]        idx, idx_end;
  logic [RES_W-1:0]        val_q;
  logic [3:0]              sh;
  logic signed [ACC_W-1:0] coef_ext, rnd, sum, shifted;
  logic [CNT_W-1:0]        end_of_size;

  always_comb begin
    case (cfg_depth)
      2'd0:    sh = 4'd7;
      2'd1:    sh = 4'd5;
      default: sh = 4'd3;
    endcase
  end

  assign coef_ext = {{(ACC_W-COEF_W){dc_coef[COEF_W-1]}}, dc_coef};
  assign rnd      = ACC_W'((1 << (sh - 4'd1)) + 1);
  assign sum      = coef_ext + rnd;
  assign shifted  = sum >>> sh;

  assign end_of_size = CNT_W'((1 << (2 * (int'(cfg_size) + 2))) - 1);

  wire take = dc_valid && !busy;
  wire move = busy && blk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      idx_end <= '0;
      val_q   <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      idx     <= '0;
      idx_end <= end_of_size;
      val_q   <= shifted[RES_W-1:0];
    end else if (move) begin
      if (idx == idx_end) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  assign dc_ready  = !busy;
  assign blk_valid = busy;
  assign blk_data  = val_q;
  assign blk_last  = busy && (idx == idx_end);
endmodule

// File: rtl/dc_fill_chk.sv
module dc_fill_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dc_valid,
  input logic        dc_ready,
  input logic [1:0]  cfg_size,
  input logic        blk_valid,
  input logic        blk_ready,
  input logic [15:0] blk_data,
  input logic        blk_last
);
  logic [9:0] beats;
  logic [1:0] sz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats <= '0;
      sz_q  <= '0;
    end else if (dc_valid && dc_ready) begin
      beats <= '0;
      sz_q  <= cfg_size;
    end else if (blk_valid && blk_ready) begin
      beats <= beats + 1'b1;
    end
  end

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dc_ready == !blk_valid);

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last));

  p_same_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && !blk_last |=> blk_valid && $stable(blk_data));

  p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_last |-> beats == 10'((1 << (2 * (int'(sz_q) + 2))) - 1));

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && blk_last |=> !blk_valid && dc_ready);
endmodule

bind dc_fill dc_fill_chk i_chk (.*);

// File: tb/test_dc_fill.sv
module test_dc_fill;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dc_valid = 1'b0, blk_ready = 1'b0;
  logic [15:0] dc_coef = '0;
  logic [1:0] cfg_size = '0, cfg_depth = '0;
  logic dc_ready, blk_valid, blk_last;
  logic [15:0] blk_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dc_fill i_dc_fill (.*);

  function automatic logic [15:0] expect_val(int dc, int dcode);
    int bd = (dcode == 0) ? 8 : (dcode == 1) ? 10 : 12;
    int r = (dc + (1 << (14 - bd)) + 1) >>> (15 - bd);
    return r[15:0];
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stall: 0 none, 1 alternate ready, 2 alternate + busy request pokes
  task automatic run_block(int dc, int sz, int dep, int stall);
    int n = 4 << sz;
    int words = 0, lasts = 0, badval = 0, lastpos = -1, holds = 0, step = 0;
    logic [15:0] exp = expect_val(dc, dep);
    logic [15:0] prev;
    logic pv = 0;
    @(negedge clk);
    check("R7 ready before request", dc_ready, dc_ready, 1);
    dc_valid = 1'b1; dc_coef = dc[15:0]; cfg_size = 2'(sz); cfg_depth = 2'(dep);
    @(negedge clk);
    dc_valid = 1'b0;
    while (words < n * n && step < 5000) begin
      blk_ready = (stall == 0) ? 1'b1 : step[0];
      if (stall == 2) begin
        dc_valid = step[1]; dc_coef = 16'h1234; cfg_size = 2'd0; cfg_depth = 2'd0;
      end
      #1;
      if (!blk_valid) break;
      if (pv && prev != blk_data) holds++;
      if (blk_data != exp) badval++;
      if (stall == 2 && dc_ready) badval++;
      if (blk_ready) begin
        if (blk_last) begin lasts++; lastpos = words; end
        words++;
      end
      prev = blk_data; pv = 1;
      step++;
      @(negedge clk);
    end
    dc_valid = 1'b0; blk_ready = 1'b0;
    check("R1/R3 word value", badval == 0, badval, 0);
    check("R4 word count", words == n * n, words, n * n);
    check("R5 last position", lasts == 1 && lastpos == n * n - 1, lastpos, n * n - 1);
    if (stall != 0) check("R6 hold under stall", holds == 0, holds, 0);
    if (stall == 2) check("R7 busy request ignored", badval == 0, badval, 0);
    #1;
    check("R9 idle after last", !blk_valid && dc_ready, blk_valid, 0);
  endtask

  task automatic test_reset();
    #1;
    check("R8 reset valid low", !blk_valid, blk_valid, 0);
    check("R8 reset ready high", dc_ready, dc_ready, 1);
  endtask

  task automatic test_sweep();
    for (int sz = 0; sz < 4; sz++)
      for (int dep = 0; dep < 3; dep++) begin
        run_block(32767, sz, dep, 0);
        run_block(-32768, sz, dep, 0);
        run_block(0, sz, dep, 0);
      end
  endtask

  task automatic test_depth3();
    // R2: code 3 must match 12-bit
    run_block(-32768, 1, 3, 0);
    run_block(32767, 0, 3, 0);
    run_block(-1, 0, 3, 0);
  endtask

  task automatic test_stalls();
    run_block(1000, 1, 1, 1);
    run_block(-777, 2, 0, 2);
    run_block(12345, 0, 2, 2);
  endtask

  task automatic test_values();
    // R1 spot points across rounding boundaries
    run_block(63, 0, 0, 0);
    run_block(-66, 0, 0, 0);
    run_block(-1, 0, 1, 0);
    run_block(11, 0, 2, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    test_sweep();
    test_depth3();
    test_stalls();
    test_values();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule